// File: doc/BRIEF.md
# Self-Test Wrapper with Learned Reference Signature

This block is a built-in self-test wrapper for a small combinational circuit that sits outside it. When a run is started, a maximal-length pseudo-random pattern generator drives the circuit's input bus through one full period of non-zero patterns. On every pattern clock, a multiple-input signature register folds the circuit's output bus into a running signature. At the end of the run both registers freeze, and the controller either keeps the final signature or judges it.

A mode input, sampled when a run is accepted, selects what happens to the final signature. In learn mode it is stored as the reference value, and the circuit attached during that run is assumed to be known-good. In check mode it is compared with the stored reference, and a pass flag reports whether the two are equal. The reference is therefore never fixed in the RTL. It is measured on a good part and then used to screen later parts that share the same wiring.

Top module: `sig_learn_bist`

## Requirements
- R1: After reset, done and pass are 0, signature is 000, and the pattern bus cut_in shows the seed 111.
- R2: An accepted start reloads the generator with 111 and clears the compactor to 000. The patterns then seen on cut_in, one per clock and read with bit 2 as the MSB, are 7, 3, 1, 4, 2, 5, 6. Each step forms the new bit 2 as bit 1 XOR bit 0, moves bit 2 into bit 1 and moves bit 1 into bit 0.
- R3: cut_in is never 000.
- R4: done is a single-cycle pulse. It is high in the 8th cycle after the cycle in which start was accepted, which means exactly 7 pattern clocks.
- R5: On each pattern clock the signature s becomes {s[1]^s[0]^y[2], s[2]^y[1], s[1]^y[0]}, where y is cut_out. signature holds the value reached after the 7th clock.
- R6: In check mode (mode = 1), pass stays 0 if no learn run has completed since reset.
- R7: A learn run (mode = 0) stores its final signature as the reference. A later check run whose final signature equals that reference raises pass together with done.
- R8: A check run whose final signature differs from the reference leaves pass at 0 and does not change the stored reference.
- R9: A start that arrives while a run is in progress, whatever the mode input is at that moment, has no effect on the timing, mode or result of that run.
- R10: A new learn run replaces the stored reference with its own final signature.
- R11: Between runs, cut_in and signature hold their values.
- R12: pass keeps its value from done until the next accepted start, and it is 0 after any learn run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Requests a run; ignored while a run is in progress |
| mode | input | 1 | 0 = learn the reference, 1 = check against the reference; sampled at start |
| cut_in | output | WIDTH | Pattern bus driving the circuit under test |
| cut_out | input | WIDTH | Response bus from the circuit under test |
| done | output | 1 | One-cycle pulse at the end of a run |
| pass | output | 1 | Check result, valid from done until the next start |
| signature | output | WIDTH | Compacted signature of the current or last run |

## Verification
The external circuit is modelled twice: as a good mapping, and as a faulty variant that inverts one output bit for a single pattern. A check before any learn run shows that pass depends on a stored reference and not on the signature value alone. Learning the good circuit and then checking the good and faulty circuits separates a match from a mismatch, and checking the good circuit again afterwards shows that a failing check left the reference alone. Relearning with the faulty circuit reverses the two verdicts, which separates replacing the reference from keeping it. A start pulse with the opposite mode in the middle of a run shows that the run's timing, mode and signature are unaffected.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic {
    SB_LEARN = 1'b0,
    SB_CHECK = 1'b1
  } sb_mode_e;

  // One right shift with the XOR of the tapped bits entering at the MSB.
  function automatic logic [31:0] sb_shift_step(input logic [31:0] v,
                                                input logic [31:0] taps,
                                                input int unsigned w);
    logic fb;
    fb = ^(v & taps);
    return (v >> 1) | ({31'd0, fb} << (w - 1));
  endfunction

  // Signature step: the shift step, then the response folded into every stage.
  function automatic logic [31:0] sb_compact_step(input logic [31:0] s,
                                                  input logic [31:0] resp,
                                                  input logic [31:0] taps,
                                                  input int unsigned w);
    return sb_shift_step(s, taps, w) ^ resp;
  endfunction

endpackage

// File: rtl/sb_pattern_gen.sv
module sb_pattern_gen #(
  parameter int unsigned WIDTH = 3,
  parameter logic [WIDTH-1:0] TAPS = 3'b011,
  parameter logic [WIDTH-1:0] SEED = 3'b111
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  output logic [WIDTH-1:0] pattern
);
  import sb_pkg::*;

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_next;

  always_comb begin
    state_next = WIDTH'(sb_shift_step(32'(state_q), 32'(TAPS), WIDTH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else if (load) begin
      state_q <= SEED;
    end else if (step) begin
      state_q <= state_next;
    end
  end

  assign pattern = state_q;

endmodule

// File: rtl/sb_sig_compactor.sv
module sb_sig_compactor #(
  parameter int unsigned WIDTH = 3,
  parameter logic [WIDTH-1:0] TAPS = 3'b011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [WIDTH-1:0] resp,
  output logic [WIDTH-1:0] sig,
  output logic [WIDTH-1:0] sig_next
);
  import sb_pkg::*;

  logic [WIDTH-1:0] sig_q;

  always_comb begin
    sig_next = WIDTH'(sb_compact_step(32'(sig_q), 32'(resp), 32'(TAPS), WIDTH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q <= '0;
    end else if (clear) begin
      sig_q <= '0;
    end else if (step) begin
      sig_q <= sig_next;
    end
  end

  assign sig = sig_q;

endmodule

// File: rtl/sb_run_ctrl.sv
module sb_run_ctrl #(
  parameter int unsigned RUN_LEN = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  sb_pkg::sb_mode_e mode,
  output logic             accept,
  output logic             step,
  output logic             finish,
  output logic             busy,
  output sb_pkg::sb_mode_e run_mode,
  output logic             done
);
  import sb_pkg::*;

  localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  sb_mode_e         mode_q;
  logic             done_q;

  assign accept   = start && !busy_q;
  assign step     = busy_q;
  assign finish   = busy_q && (cnt_q == LAST);
  assign busy     = busy_q;
  assign run_mode = mode_q;
  assign done     = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      mode_q <= SB_LEARN;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (accept) begin
        cnt_q  <= '0;
        busy_q <= 1'b1;
        mode_q <= mode;
      end else if (finish) begin
        cnt_q  <= '0;
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sb_golden_store.sv
module sb_golden_store #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [WIDTH-1:0] final_sig,
  output logic             ref_valid,
  output logic             match
);
  logic [WIDTH-1:0] ref_q;
  logic             valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q   <= '0;
      valid_q <= 1'b0;
    end else if (capture) begin
      ref_q   <= final_sig;
      valid_q <= 1'b1;
    end
  end

  assign ref_valid = valid_q;
  assign match     = valid_q && (final_sig == ref_q);

endmodule

// File: rtl/sig_learn_bist.sv
module sig_learn_bist #(
  parameter int unsigned WIDTH = 3,
  parameter logic [WIDTH-1:0] TAPS = 3'b011,
  parameter logic [WIDTH-1:0] SEED = 3'b111
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode,
  output logic [WIDTH-1:0] cut_in,
  input  logic [WIDTH-1:0] cut_out,
  output logic             done,
  output logic             pass,
  output logic [WIDTH-1:0] signature
);
  import sb_pkg::*;

  localparam int unsigned RUN_LEN = (1 << WIDTH) - 1;

  // Named internal events, visible to the bound checker.
  logic             run_accept;
  logic             run_step;
  logic             run_finish;
  logic             run_busy;
  sb_mode_e         run_mode;
  logic             learn_capture;
  logic             ref_valid;
  logic             ref_match;
  logic [WIDTH-1:0] sig_next;
  logic             pass_q;

  sb_run_ctrl #(.RUN_LEN(RUN_LEN)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mode     (sb_mode_e'(mode)),
    .accept   (run_accept),
    .step     (run_step),
    .finish   (run_finish),
    .busy     (run_busy),
    .run_mode (run_mode),
    .done     (done)
  );

  sb_pattern_gen #(.WIDTH(WIDTH), .TAPS(TAPS), .SEED(SEED)) u_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (run_accept),
    .step    (run_step),
    .pattern (cut_in)
  );

  sb_sig_compactor #(.WIDTH(WIDTH), .TAPS(TAPS)) u_misr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (run_accept),
    .step     (run_step),
    .resp     (cut_out),
    .sig      (signature),
    .sig_next (sig_next)
  );

  assign learn_capture = run_finish && (run_mode == SB_LEARN);

  sb_golden_store #(.WIDTH(WIDTH)) u_ref (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (learn_capture),
    .final_sig (sig_next),
    .ref_valid (ref_valid),
    .match     (ref_match)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q <= 1'b0;
    end else if (run_accept) begin
      pass_q <= 1'b0;
    end else if (run_finish) begin
      pass_q <= (run_mode == SB_CHECK) && ref_match;
    end
  end

  assign pass = pass_q;

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int unsigned WIDTH = 3,
  parameter logic [WIDTH-1:0] SEED = 3'b111
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             run_accept,
  input logic             run_busy,
  input logic             ref_valid,
  input logic [WIDTH-1:0] cut_in,
  input logic [WIDTH-1:0] signature,
  input logic             done,
  input logic             pass
);
  localparam int unsigned RUN_LEN = (1 << WIDTH) - 1;
  localparam int unsigned CW = $clog2(RUN_LEN + 2) + 1;

  logic [CW-1:0] since_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_accept <= '0;
    end else if (run_accept) begin
      since_accept <= CW'(1);
    end else if (done) begin
      since_accept <= '0;
    end else if (since_accept != '0) begin
      since_accept <= since_accept + 1'b1;
    end
  end

  AST_NONZERO_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    cut_in != '0); // R3

  AST_LOAD_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    run_accept |=> (cut_in == SEED) && (signature == '0)); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4

  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (since_accept == CW'(RUN_LEN + 1))); // R4

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (run_busy && start) |-> !run_accept); // R9

  AST_PASS_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> ref_valid); // R6

  AST_PASS_RISES_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass) |-> done); // R7

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_busy && !start) |=> $stable(cut_in) && $stable(signature)); // R11

  AST_PASS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_busy && !start && !done) |=> $stable(pass)); // R12

endmodule

bind sig_learn_bist sb_checker #(.WIDTH(WIDTH), .SEED(SEED)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .run_accept (run_accept),
  .run_busy   (run_busy),
  .ref_valid  (ref_valid),
  .cut_in     (cut_in),
  .signature  (signature),
  .done       (done),
  .pass       (pass)
);

// File: tb/test_sig_learn_bist.sv
module test_sig_learn_bist;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       mode = 1'b0;
  logic [2:0] cut_in;
  logic [2:0] cut_out;
  logic       done;
  logic       pass;
  logic [2:0] signature;
  logic       faulty = 1'b0;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  // Bench model state for the reference.
  logic [2:0] model_ref = 3'b000;
  bit         model_ref_ok = 0;

  always #4 clk = ~clk;

  sig_learn_bist i_sig_learn_bist (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (mode),
    .cut_in    (cut_in),
    .cut_out   (cut_out),
    .done      (done),
    .pass      (pass),
    .signature (signature)
  );

  // Circuit under test model; the faulty variant flips y[0] for pattern 5.
  function automatic logic [2:0] cut_fn(input logic [2:0] x, input bit bad);
    logic [2:0] y;
    y[2] = x[2] & x[1];
    y[1] = x[1] ^ x[0];
    y[0] = ~x[2] | x[0];
    if (bad && x == 3'd5) y[0] = ~y[0];
    return y;
  endfunction

  always_comb cut_out = cut_fn(cut_in, faulty);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected pattern k (0..6) from the stated bit rule.
  function automatic logic [2:0] exp_pattern(input int k);
    logic q0, q1, q2, n0;
    q0 = 1; q1 = 1; q2 = 1;
    for (int i = 0; i < k; i++) begin
      n0 = q1 ^ q2;
      q2 = q1;
      q1 = q0;
      q0 = n0;
    end
    return {q0, q1, q2};
  endfunction

  function automatic logic [2:0] exp_sig(input bit bad);
    logic [2:0] s, y;
    s = 3'b000;
    for (int k = 0; k < 7; k++) begin
      y = cut_fn(exp_pattern(k), bad);
      s = {s[1] ^ s[0] ^ y[2], s[2] ^ y[1], s[1] ^ y[0]};
    end
    return s;
  endfunction

  // One run; checks R2 R3 R4 R5 and the verdict (R6 R7 R8 R10 R12).
  task automatic do_run(input bit m, input bit bad, input bit poke_busy,
                        input string req);
    logic [2:0] es;
    bit ep;
    faulty = bad;
    mode = m;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int k = 0; k < 7; k++) begin
      check(cut_in == exp_pattern(k), "R2", "pattern", cut_in, exp_pattern(k));
      check(cut_in != 3'b000, "R3", "nonzero pattern", cut_in, 1);
      check(done == 1'b0, "R4", "done early", done, 0);
      if (poke_busy && k == 3) begin
        start = 1'b1;
        mode = ~m;
      end
      @(negedge clk);
      start = 1'b0;
      mode = m;
    end
    es = exp_sig(bad);
    if (m) ep = model_ref_ok && (es == model_ref);
    else begin
      ep = 0;
      model_ref = es;
      model_ref_ok = 1;
    end
    check(done == 1'b1, poke_busy ? "R9" : "R4", "done after 7 clocks", done, 1);
    check(signature == es, poke_busy ? "R9" : "R5", "signature", signature, es);
    check(pass == ep, req, "pass", pass, ep);
    @(negedge clk);
    check(done == 1'b0, "R4", "done one cycle", done, 0);
  endtask

  task automatic t_reset;
    check(done == 0, "R1", "reset done", done, 0);
    check(pass == 0, "R1", "reset pass", pass, 0);
    check(signature == 3'b000, "R1", "reset signature", signature, 0);
    check(cut_in == 3'b111, "R1", "reset pattern", cut_in, 7);
  endtask

  task automatic t_check_before_learn;
    do_run(1'b1, 1'b0, 1'b0, "R6");
  endtask

  task automatic t_learn_then_check;
    do_run(1'b0, 1'b0, 1'b0, "R12");
    do_run(1'b1, 1'b0, 1'b0, "R7");
  endtask

  task automatic t_faulty_check;
    check(exp_sig(1'b1) != exp_sig(1'b0), "R8", "fault visible", 1, 1);
    do_run(1'b1, 1'b1, 1'b0, "R8");
    do_run(1'b1, 1'b0, 1'b0, "R8");
  endtask

  task automatic t_busy_start;
    do_run(1'b1, 1'b0, 1'b1, "R9");
  endtask

  task automatic t_idle_hold;
    logic [2:0] s0;
    logic p0;
    s0 = signature;
    p0 = pass;
    for (int i = 0; i < 5; i++) begin
      mode = i[0];
      faulty = i[1];
      @(negedge clk);
      check(cut_in == 3'b111, "R11", "idle pattern", cut_in, 7);
      check(signature == s0, "R11", "idle signature", signature, s0);
      check(pass == p0, "R12", "pass held", pass, p0);
    end
    faulty = 1'b0;
  endtask

  task automatic t_relearn;
    do_run(1'b0, 1'b1, 1'b0, "R12");
    do_run(1'b1, 1'b1, 1'b0, "R10");
    do_run(1'b1, 1'b0, 1'b0, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_check_before_learn();
    t_learn_then_check();
    t_faulty_check();
    t_busy_start();
    t_idle_hold();
    t_relearn();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 20000, 0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule